// File: doc/BRIEF.md
# LPDDR2 Mode-Register Initialization Sequencer

This block brings two LPDDR2 chip selects from power-up to an operational state. A single-cycle `start` pulse launches a fixed recipe of Mode Register Write commands. The recipe is a device reset, then ZQ calibration, then the burst-control, latency and drive-strength registers. Every step goes to chip select 0 and then to chip select 1 before the next step begins. Each command is placed on a command port with a valid strobe, and it stays there until the downstream command layer answers with `cmd_ready`.

Between commands the sequencer holds the port idle for a fixed number of cycles. All of these counts are parameters in clock cycles. A short mode-register gap applies by default. A long wait follows the device reset, and a calibration wait follows the ZQ command. A settle interval counts clock-enable hold time before the first command. When the final write is accepted, `done` pulses for one cycle and the block returns to idle, ready to run the recipe again.

Top module: `lpddr2_mrw_init`

## Requirements
- R1: Out of reset, and while idle with no `start`, `cmd_valid` and `done` are low.
- R2: After `start` is sampled in the idle state, `cmd_valid` stays low for exactly `CKE_CYC` cycles and then rises for the first command.
- R3: Exactly ten commands are issued, as (chip select, address, opcode) in this order: (0,63,0x00) (1,63,0x00) (0,10,0xFF) (1,10,0xFF) (0,1,0x82) (1,1,0x82) (0,2,0x04) (1,2,0x04) (0,3,0x01) (1,3,0x01).
- R4: While `cmd_valid` is high and `cmd_ready` is low, the command stays asserted and `cmd_cs`, `cmd_ma` and `cmd_op` do not change.
- R5: A command is accepted in a cycle where `cmd_valid` and `cmd_ready` are both high. Unless R6 or R7 applies, `cmd_valid` is then low for exactly `MRD_CYC` cycles before the next command.
- R6: After the reset command (address 63) to chip select 1 is accepted, `cmd_valid` is low for exactly `RST_WAIT_CYC` cycles.
- R7: After the calibration command (address 10) to chip select 1 is accepted, `cmd_valid` is low for exactly `ZQ_WAIT_CYC` cycles.
- R8: `done` is high for exactly one cycle, the cycle after the last command is accepted, and no further command follows.
- R9: A `start` pulse during a running sequence has no effect: order, gaps and the single `done` pulse are unchanged.
- R10: After `done`, a new `start` runs the complete recipe again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch the recipe when idle |
| done | output | 1 | One-cycle pulse after the last write is accepted |
| cmd_valid | output | 1 | Command present on the port |
| cmd_cs | output | CS_W | Target chip select |
| cmd_ma | output | 8 | Mode-register address |
| cmd_op | output | 8 | Mode-register opcode |
| cmd_ready | input | 1 | Command layer accepts the current command |

## Verification
The bench builds the block with `CKE_CYC=3`, `MRD_CYC=3`, `RST_WAIT_CYC=17` and `ZQ_WAIT_CYC=29`. These replace the microsecond-scale defaults, so the whole recipe runs in about a hundred cycles. The values differ from each other, so if the wrong wait is chosen after a step, the idle-cycle count gives a distinct wrong number. Because the runs are short, one test can throttle `cmd_ready` to stretch every command, inject `start` pulses in the middle of a sequence, and run the recipe twice in succession.

// File: rtl/mrw_init_pkg.sv
package mrw_init_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ISSUE
    } seq_state_e;

    typedef enum logic [1:0] {
        GAP_MRD,
        GAP_RST,
        GAP_ZQ,
        GAP_END
    } gap_kind_e;

    localparam int STEP_COUNT = 5;

    // Mode-register address for each recipe step.
    function automatic logic [7:0] step_addr(input int unsigned step);
        case (step)
            0:       step_addr = 8'd63;
            1:       step_addr = 8'd10;
            2:       step_addr = 8'd1;
            3:       step_addr = 8'd2;
            default: step_addr = 8'd3;
        endcase
    endfunction

    // Opcode written at each step.
    function automatic logic [7:0] step_opcode(input int unsigned step);
        case (step)
            0:       step_opcode = 8'h00;
            1:       step_opcode = 8'hFF;
            2:       step_opcode = 8'h82;
            3:       step_opcode = 8'h04;
            default: step_opcode = 8'h01;
        endcase
    endfunction

    // Wait that follows a step once its last chip select is served.
    function automatic gap_kind_e step_tail_gap(input int unsigned step);
        case (step)
            0:       step_tail_gap = GAP_RST;
            1:       step_tail_gap = GAP_ZQ;
            4:       step_tail_gap = GAP_END;
            default: step_tail_gap = GAP_MRD;
        endcase
    endfunction

endpackage

// File: rtl/mrw_step_decode.sv
module mrw_step_decode
    import mrw_init_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int IDX_W  = 4,
    parameter int CS_W   = 1
) (
    input  logic [IDX_W-1:0] idx,
    output logic [CS_W-1:0]  cs,
    output logic [7:0]       ma,
    output logic [7:0]       op,
    output logic             last_cmd,
    output gap_kind_e        gap_after
);
    localparam int NUM_CMD = STEP_COUNT * NUM_CS;

    int unsigned step_w;
    int unsigned cs_w;

    always_comb begin
        step_w    = int'(idx) / NUM_CS;
        cs_w      = int'(idx) % NUM_CS;
        cs        = CS_W'(cs_w);
        ma        = step_addr(step_w);
        op        = step_opcode(step_w);
        last_cmd  = (int'(idx) == NUM_CMD - 1);
        gap_after = (cs_w == NUM_CS - 1) ? step_tail_gap(step_w) : GAP_MRD;
    end

endmodule

// File: rtl/mrw_gap_timer.sv
module mrw_gap_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = load_val;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired = (tmr_q.cnt == '0);

    // R5: an unloaded, running count steps down by one per cycle
    p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tmr_q.cnt != '0) |=> (tmr_q.cnt == $past(tmr_q.cnt) - 1'b1));

endmodule

// File: rtl/lpddr2_mrw_init.sv
module lpddr2_mrw_init
    import mrw_init_pkg::*;
#(
    parameter int NUM_CS       = 2,
    parameter int CKE_CYC      = 3,
    parameter int MRD_CYC      = 3,
    parameter int RST_WAIT_CYC = 4000,
    parameter int ZQ_WAIT_CYC  = 400,
    localparam int CS_W        = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            done,
    output logic            cmd_valid,
    output logic [CS_W-1:0] cmd_cs,
    output logic [7:0]      cmd_ma,
    output logic [7:0]      cmd_op,
    input  logic            cmd_ready
);
    localparam int NUM_CMD = STEP_COUNT * NUM_CS;
    localparam int IDX_W   = $clog2(NUM_CMD);
    localparam int MAX_A   = (CKE_CYC > MRD_CYC) ? CKE_CYC : MRD_CYC;
    localparam int MAX_B   = (RST_WAIT_CYC > ZQ_WAIT_CYC) ? RST_WAIT_CYC : ZQ_WAIT_CYC;
    localparam int MAX_W   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_W + 1);

    typedef struct packed {
        seq_state_e       state;
        logic [IDX_W-1:0] idx;
        logic             done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             last_cmd;
    gap_kind_e        gap_after;
    logic             accept;

    mrw_step_decode #(
        .NUM_CS (NUM_CS),
        .IDX_W  (IDX_W),
        .CS_W   (CS_W)
    ) u_decode (
        .idx       (seq_q.idx),
        .cs        (cmd_cs),
        .ma        (cmd_ma),
        .op        (cmd_op),
        .last_cmd  (last_cmd),
        .gap_after (gap_after)
    );

    mrw_gap_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    assign cmd_valid = (seq_q.state == ST_ISSUE);
    assign accept    = cmd_valid && cmd_ready;
    assign done      = seq_q.done;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (start) begin
                    seq_d.state = ST_WAIT;
                    seq_d.idx   = '0;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(CKE_CYC - 1);
                end
            end
            ST_WAIT: begin
                if (tmr_expired) seq_d.state = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (cmd_ready) begin
                    if (last_cmd) begin
                        seq_d.state = ST_IDLE;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.state = ST_WAIT;
                        seq_d.idx   = seq_q.idx + 1'b1;
                        tmr_load    = 1'b1;
                        case (gap_after)
                            GAP_RST: tmr_val = CNT_W'(RST_WAIT_CYC - 1);
                            GAP_ZQ:  tmr_val = CNT_W'(ZQ_WAIT_CYC - 1);
                            default: tmr_val = CNT_W'(MRD_CYC - 1);
                        endcase
                    end
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_IDLE;
            seq_q.idx   <= '0;
            seq_q.done  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // R4: a stalled command stays on the port unchanged
    p_hold_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_cs) && $stable(cmd_ma) && $stable(cmd_op)));

    // R3: each acceptance advances to the next entry of the recipe
    p_next_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !last_cmd) |=> (seq_q.idx == $past(seq_q.idx) + 1'b1));

    // R8: done lasts a single cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done only follows acceptance of the final command, with the port idle
    p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && last_cmd) |=> (done && !cmd_valid));

    // R9: start inside a running sequence does not move the recipe position
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state != ST_IDLE && start && !accept) |=> $stable(seq_q.idx));

endmodule

// File: tb/tb_lpddr2_mrw_init.sv
`timescale 1ns/1ps
module tb_lpddr2_mrw_init;
    localparam int CKE  = 3;
    localparam int MRD  = 3;
    localparam int RSTW = 17;
    localparam int ZQW  = 29;
    localparam int NCMD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       cmd_ready = 1'b0;
    logic       done;
    logic       cmd_valid;
    logic [0:0] cmd_cs;
    logic [7:0] cmd_ma;
    logic [7:0] cmd_op;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    lpddr2_mrw_init #(
        .NUM_CS       (2),
        .CKE_CYC      (CKE),
        .MRD_CYC      (MRD),
        .RST_WAIT_CYC (RSTW),
        .ZQ_WAIT_CYC  (ZQW)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .done      (done),
        .cmd_valid (cmd_valid),
        .cmd_cs    (cmd_cs),
        .cmd_ma    (cmd_ma),
        .cmd_op    (cmd_op),
        .cmd_ready (cmd_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_ma(input int n);
        int t[5] = '{63, 10, 1, 2, 3};
        return t[n / 2];
    endfunction

    function automatic int exp_op(input int n);
        int t[5] = '{8'h00, 8'hFF, 8'h82, 8'h04, 8'h01};
        return t[n / 2];
    endfunction

    function automatic int exp_gap(input int n);
        if (n == 0) return CKE;
        if (n == 2) return RSTW;
        if (n == 4) return ZQW;
        return MRD;
    endfunction

    function automatic string gap_req(input int n);
        if (n == 0) return "R2";
        if (n == 2) return "R6";
        if (n == 4) return "R7";
        return "R5";
    endfunction

    // Run one full recipe. mode 0: always ready, mode 1: ready every third cycle.
    task automatic run_seq(input int mode, input bit poke, input string tag);
        int  accepted   = 0;
        int  low_run    = 0;
        int  done_count = 0;
        int  tail       = -1;
        bit  first      = 1'b1;
        bit  prev_stall = 1'b0;
        bit  exp_done   = 1'b0;
        int  p_cs = 0, p_ma = 0, p_op = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            cmd_ready = (mode == 0) ? 1'b1 : (cyc % 3 == 2);
            start     = poke && (cyc == 20 || cyc == 60 || cyc == 2);
            #0.1;
            if (prev_stall) begin
                chk(cmd_valid === 1'b1, "R4", {tag, " stalled valid held"}, int'(cmd_valid), 1);
                chk(cmd_cs == p_cs && cmd_ma == p_ma && cmd_op == p_op, "R4",
                    {tag, " stalled fields stable (ma)"}, int'(cmd_ma), p_ma);
            end
            if (done || exp_done)
                chk(done === exp_done, "R8", {tag, " done timing"}, int'(done), int'(exp_done));
            if (done) done_count++;
            exp_done = 1'b0;
            if (cmd_valid) begin
                chk(accepted < NCMD, "R8", {tag, " no command after last"}, accepted, NCMD - 1);
                if (first && accepted < NCMD) begin
                    chk(low_run == exp_gap(accepted), gap_req(accepted), {tag, " idle cycles before command"},
                        low_run, exp_gap(accepted));
                    chk(int'(cmd_cs) == accepted % 2, "R3", {tag, " chip select"}, int'(cmd_cs), accepted % 2);
                    chk(int'(cmd_ma) == exp_ma(accepted), "R3", {tag, " address"}, int'(cmd_ma), exp_ma(accepted));
                    chk(int'(cmd_op) == exp_op(accepted), "R3", {tag, " opcode"}, int'(cmd_op), exp_op(accepted));
                    first = 1'b0;
                end
                if (cmd_ready) begin
                    accepted++;
                    low_run = 0;
                    first   = 1'b1;
                    if (accepted == NCMD) begin
                        exp_done = 1'b1;
                        tail     = 12;
                    end
                end
            end else begin
                low_run++;
            end
            prev_stall = cmd_valid && !cmd_ready;
            p_cs = int'(cmd_cs); p_ma = int'(cmd_ma); p_op = int'(cmd_op);
            if (tail == 0) break;
            if (tail > 0) tail--;
            @(negedge clk);
        end
        start     = 1'b0;
        cmd_ready = 1'b0;
        chk(accepted == NCMD, poke ? "R9" : "R3", {tag, " command count"}, accepted, NCMD);
        chk(done_count == 1, poke ? "R9" : "R8", {tag, " done pulses"}, done_count, 1);
    endtask

    task automatic test_reset_idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(cmd_valid === 1'b0, "R1", "valid in reset", int'(cmd_valid), 0);
        chk(done === 1'b0, "R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        cmd_ready = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(cmd_valid === 1'b0 && done === 1'b0, "R1", "idle without start", int'(cmd_valid), 0);
        end
        cmd_ready = 1'b0;
    endtask

    task automatic test_always_ready();
        run_seq(0, 1'b0, "ready");
    endtask

    task automatic test_stalls();
        run_seq(1, 1'b0, "stall R4");
    endtask

    task automatic test_start_ignored();
        run_seq(0, 1'b1, "poke R9");
        run_seq(1, 1'b1, "poke-stall R9");
    endtask

    task automatic test_rerun();
        run_seq(0, 1'b0, "rerun-a R10");
        run_seq(0, 1'b0, "rerun-b R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        test_reset_idle();
        test_always_ready();
        test_stalls();
        test_start_ignored();
        test_rerun();
        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule